// File: doc/BRIEF.md
# 100BASE-TX PCS Receive Framer

This block is the receive half of a 100 Mb/s fast-Ethernet physical coding sublayer. It takes one code bit per clock from the physical medium side. By this point the bits have been recovered, line-decoded and descrambled. While the line carries idle, the block hunts for a start-of-stream delimiter. When it finds one, it locks 5-bit symbol framing to that delimiter and presents decoded 4-bit nibbles on a media-independent style receive interface. That interface has data, data-valid, error and carrier-sense outputs.

The block replaces the start delimiter with two preamble nibbles. It removes the end delimiter from the data. It flags invalid code groups without leaving the frame. A frame that falls back to idle before its end delimiter is reported as a premature end. This sets a sticky flag, which software clears with a read strobe. A delimiter search that fails is reported as a false carrier.

A new nibble is presented once per symbol period, and a one-cycle strobe marks it. Between strobes every receive output holds its value.

Top module: `pcs100_rx`

## Requirements
- R1: While `rst_ni` is low, and until the first strobe after reset, `rxd_o`, `rx_dv_o`, `rx_er_o`, `crs_o`, `nib_stb_o` and `prem_end_o` are all 0.
- R2: A stream of continuous ones produces no strobe and leaves `crs_o` low.
- R3: A zero in the idle line opens a 10-bit search group, which starts two bits before that zero. `crs_o` rises one clock after the bit that completes two zeros separated by at least one one inside the group. A single run of adjacent zeros raises no carrier and produces no strobe.
- R4: If the search group equals 11000_10001 (first bit leftmost), two nibbles 0101 are presented with `rx_dv_o` high and `crs_o` high. The first is strobed one clock after the group's last bit. `rx_dv_o` only rises on such a nibble.
- R5: Each later code group is decoded by the standard 4B/5B table (for example 11110→0, 01011→5, 11101→F, first bit leftmost). The resulting nibble is strobed five clocks after the next group boundary, so all strobes within a frame fall exactly five clocks apart.
- R6: A 01101 group followed by 00111 ends the frame. The nibble strobed at the 00111 boundary has `rx_dv_o`, `rx_er_o` and `crs_o` low, and neither group is ever presented as data.
- R7: A code group that is neither data, 01101 nor 11111 is presented as one nibble with `rx_dv_o` and `rx_er_o` both high. Reception then continues with the next group.
- R8: A 11111 group in place of data presents the pending nibble with `rx_er_o` high and sets `prem_end_o`. Five clocks later a strobe clears `rx_dv_o`, `rx_er_o` and `crs_o`.
- R9: A search group that has carrier but is not 11000_10001 presents `rxd_o`=1110 with `rx_er_o` high, `rx_dv_o` low and `crs_o` high. This holds until ten consecutive ones have arrived after the decision. The strobe after the tenth one clears `rx_er_o` and `crs_o`.
- R10: `prem_end_o` stays set until a `stat_rd_i` pulse, and reads 0 on the clock after that pulse.
- R11: The receive outputs change only on a strobe, no two strobes are adjacent, and `rx_dv_o` is never high while `crs_o` is low.
- R12: A 01101 group followed by anything other than 00111 presents a nibble with `rx_er_o` high and `rx_dv_o` low. Five clocks later a clearing strobe returns the block to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit clock, one code bit per cycle |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_bit_i | input | 1 | Received code bit |
| stat_rd_i | input | 1 | Status read strobe, clears the premature-end flag |
| rxd_o | output | 4 | Received nibble |
| rx_dv_o | output | 1 | Receive data valid |
| rx_er_o | output | 1 | Receive error |
| crs_o | output | 1 | Carrier sense |
| nib_stb_o | output | 1 | One-cycle pulse when a new nibble is presented |
| prem_end_o | output | 1 | Sticky premature-end status |

## Verification
A frame carrying all sixteen data code groups tests the decoder and the fixed five-clock cadence. This separates correct symbol alignment from an off-by-one framing error. Several other patterns each test one kind of behaviour: idle only, adjacent-zero noise, a non-delimiter pattern with two separated zeros, an invalid group mid-frame, an early return to idle, and an end delimiter with a wrong second half. Together these separate carrier detection from delimiter acceptance, and a recoverable error from a frame abort. The bench also reads the sticky flag before and after its read strobe.

// File: rtl/pcs100_rx_pkg.sv
package pcs100_rx_pkg;
  localparam int SYM_W = 5;
  localparam int NIB_W = 4;
  localparam int WIN_W = 2 * SYM_W;

  localparam logic [SYM_W-1:0] C_SSD1 = 5'b11000;
  localparam logic [SYM_W-1:0] C_SSD2 = 5'b10001;
  localparam logic [SYM_W-1:0] C_ESD1 = 5'b01101;
  localparam logic [SYM_W-1:0] C_ESD2 = 5'b00111;
  localparam logic [SYM_W-1:0] C_IDLE = 5'b11111;
  localparam logic [WIN_W-1:0] C_SSD  = {C_SSD1, C_SSD2};

  localparam logic [NIB_W-1:0] PRE_NIB = 4'b0101;
  localparam logic [NIB_W-1:0] FC_NIB  = 4'b1110;

  typedef enum logic [2:0] {
    SYM_DATA, SYM_BAD, SYM_ESD1, SYM_ESD2, SYM_IDLE
  } sym_kind_e;

  typedef enum logic [2:0] {
    ST_HUNT, ST_ARM, ST_RECV, ST_ENDR, ST_DRAIN, ST_FALSE
  } rx_state_e;
endpackage

// File: rtl/pcs100_rx_deser.sv
module pcs100_rx_deser #(
  parameter int WIN_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bit_i,
  output logic [WIN_W-1:0] win_o
);
  logic [WIN_W-2:0] sh_q;

  // newest bit at LSB, so the oldest bit of a group sits at its MSB
  assign win_o = {sh_q, bit_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '1;
    else         sh_q <= win_o[WIN_W-2:0];
  end
endmodule

// File: rtl/pcs100_rx_decode.sv
module pcs100_rx_decode
  import pcs100_rx_pkg::*;
(
  input  logic [SYM_W-1:0] code_i,
  output logic [NIB_W-1:0] nib_o,
  output sym_kind_e        kind_o
);
  always_comb begin
    nib_o  = '0;
    kind_o = SYM_DATA;
    unique case (code_i)
      5'b11110: nib_o = 4'h0;
      5'b01001: nib_o = 4'h1;
      5'b10100: nib_o = 4'h2;
      5'b10101: nib_o = 4'h3;
      5'b01010: nib_o = 4'h4;
      5'b01011: nib_o = 4'h5;
      5'b01110: nib_o = 4'h6;
      5'b01111: nib_o = 4'h7;
      5'b10010: nib_o = 4'h8;
      5'b10011: nib_o = 4'h9;
      5'b10110: nib_o = 4'hA;
      5'b10111: nib_o = 4'hB;
      5'b11010: nib_o = 4'hC;
      5'b11011: nib_o = 4'hD;
      5'b11100: nib_o = 4'hE;
      5'b11101: nib_o = 4'hF;
      C_ESD1:   kind_o = SYM_ESD1;
      C_ESD2:   kind_o = SYM_ESD2;
      C_IDLE:   kind_o = SYM_IDLE;
      default:  kind_o = SYM_BAD;
    endcase
  end
endmodule

// File: rtl/pcs100_rx_status.sv
module pcs100_rx_status (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic rd_i,
  output logic flag_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    flag_o <= 1'b0;
    else if (set_i) flag_o <= 1'b1;  // set wins over a coincident read
    else if (rd_i)  flag_o <= 1'b0;
  end
endmodule

// File: rtl/pcs100_rx.sv
module pcs100_rx
  import pcs100_rx_pkg::*;
#(
  parameter int IDLE_RUN = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rx_bit_i,
  input  logic             stat_rd_i,
  output logic [NIB_W-1:0] rxd_o,
  output logic             rx_dv_o,
  output logic             rx_er_o,
  output logic             crs_o,
  output logic             nib_stb_o,
  output logic             prem_end_o
);
  localparam int CNT_W   = $clog2(WIN_W);
  localparam int ARM_LEN = WIN_W - 3;  // bits after the first zero
  localparam int ONES_W  = $clog2(IDLE_RUN + 1);
  localparam logic [CNT_W-1:0]  ARM_LAST = CNT_W'(ARM_LEN - 1);
  localparam logic [CNT_W-1:0]  SYM_LAST = CNT_W'(SYM_W - 1);
  localparam logic [ONES_W-1:0] RUN_LAST = ONES_W'(IDLE_RUN - 1);

  logic [WIN_W-1:0] win;
  logic [NIB_W-1:0] dec_nib;
  sym_kind_e        dec_kind;

  rx_state_e         state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [ONES_W-1:0] ones_q;
  logic              seen1_q, car_q;
  logic [NIB_W-1:0]  hold_nib_q;
  logic              hold_er_q;
  logic              prem_set;
  logic              car_now, sym_end;

  pcs100_rx_deser #(.WIN_W(WIN_W)) u_deser (
    .clk_i(clk_i), .rst_ni(rst_ni), .bit_i(rx_bit_i), .win_o(win)
  );

  pcs100_rx_decode u_dec (
    .code_i(win[SYM_W-1:0]), .nib_o(dec_nib), .kind_o(dec_kind)
  );

  pcs100_rx_status u_stat (
    .clk_i(clk_i), .rst_ni(rst_ni), .set_i(prem_set), .rd_i(stat_rd_i),
    .flag_o(prem_end_o)
  );

  assign car_now  = car_q | (!rx_bit_i & seen1_q);
  assign sym_end  = (cnt_q == SYM_LAST);
  assign prem_set = (state_q == ST_RECV) && sym_end && (dec_kind == SYM_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_HUNT;
      cnt_q      <= '0;
      ones_q     <= '0;
      seen1_q    <= 1'b0;
      car_q      <= 1'b0;
      hold_nib_q <= '0;
      hold_er_q  <= 1'b0;
      rxd_o      <= '0;
      rx_dv_o    <= 1'b0;
      rx_er_o    <= 1'b0;
      crs_o      <= 1'b0;
      nib_stb_o  <= 1'b0;
    end else begin
      nib_stb_o <= 1'b0;
      unique case (state_q)
        ST_HUNT: begin
          if (!rx_bit_i) begin
            state_q <= ST_ARM;
            cnt_q   <= '0;
            seen1_q <= 1'b0;
            car_q   <= 1'b0;
          end
        end
        ST_ARM: begin
          cnt_q <= cnt_q + 1'b1;
          if (rx_bit_i) seen1_q <= 1'b1;
          if (car_now) begin
            car_q <= 1'b1;
            crs_o <= 1'b1;
          end
          if (cnt_q == ARM_LAST) begin
            if (!car_now) begin
              state_q <= ST_HUNT;
            end else if (win == C_SSD) begin
              state_q    <= ST_RECV;
              cnt_q      <= '0;
              rxd_o      <= PRE_NIB;
              rx_dv_o    <= 1'b1;
              rx_er_o    <= 1'b0;
              nib_stb_o  <= 1'b1;
              hold_nib_q <= PRE_NIB;  // second preamble nibble
              hold_er_q  <= 1'b0;
            end else begin
              state_q   <= ST_FALSE;
              ones_q    <= '0;
              rxd_o     <= FC_NIB;
              rx_dv_o   <= 1'b0;
              rx_er_o   <= 1'b1;
              nib_stb_o <= 1'b1;
            end
          end
        end
        ST_RECV: begin
          cnt_q <= sym_end ? '0 : cnt_q + 1'b1;
          if (sym_end) begin
            rxd_o     <= hold_nib_q;
            rx_dv_o   <= 1'b1;
            nib_stb_o <= 1'b1;
            rx_er_o   <= hold_er_q;
            unique case (dec_kind)
              SYM_ESD1: state_q <= ST_ENDR;
              SYM_IDLE: begin
                rx_er_o <= 1'b1;
                state_q <= ST_DRAIN;
              end
              SYM_DATA: begin
                hold_nib_q <= dec_nib;
                hold_er_q  <= 1'b0;
              end
              default: begin
                hold_nib_q <= '0;
                hold_er_q  <= 1'b1;
              end
            endcase
          end
        end
        ST_ENDR: begin
          cnt_q <= sym_end ? '0 : cnt_q + 1'b1;
          if (sym_end) begin
            rxd_o     <= '0;
            rx_dv_o   <= 1'b0;
            crs_o     <= 1'b0;
            nib_stb_o <= 1'b1;
            if (dec_kind == SYM_ESD2) begin
              rx_er_o <= 1'b0;
              state_q <= ST_HUNT;
            end else begin
              rx_er_o <= 1'b1;
              state_q <= ST_DRAIN;
            end
          end
        end
        ST_DRAIN: begin
          cnt_q <= sym_end ? '0 : cnt_q + 1'b1;
          if (sym_end) begin
            rxd_o     <= '0;
            rx_dv_o   <= 1'b0;
            rx_er_o   <= 1'b0;
            crs_o     <= 1'b0;
            nib_stb_o <= 1'b1;
            state_q   <= ST_HUNT;
          end
        end
        ST_FALSE: begin
          if (!rx_bit_i) begin
            ones_q <= '0;
          end else if (ones_q == RUN_LAST) begin
            rxd_o     <= '0;
            rx_er_o   <= 1'b0;
            crs_o     <= 1'b0;
            nib_stb_o <= 1'b1;
            state_q   <= ST_HUNT;
          end else begin
            ones_q <= ones_q + 1'b1;
          end
        end
        default: state_q <= ST_HUNT;
      endcase
    end
  end
endmodule

// File: rtl/pcs100_rx_chk.sv
module pcs100_rx_chk
  import pcs100_rx_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             stat_rd_i,
  input logic [NIB_W-1:0] rxd_o,
  input logic             rx_dv_o,
  input logic             rx_er_o,
  input logic             crs_o,
  input logic             nib_stb_o,
  input logic             prem_end_o
);
  p_hold_between_stb_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !nib_stb_o |-> ($stable(rxd_o) && $stable(rx_dv_o) && $stable(rx_er_o)));

  p_stb_gap_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nib_stb_o |=> !nib_stb_o);

  p_dv_needs_crs_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_dv_o |-> crs_o);

  p_dv_rise_preamble_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rx_dv_o) |-> (rxd_o == PRE_NIB));

  p_false_carrier_code_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_er_o && !rx_dv_o && crs_o) |-> (rxd_o == FC_NIB));

  p_sticky_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prem_end_o && !stat_rd_i) |=> prem_end_o);
endmodule

bind pcs100_rx pcs100_rx_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .stat_rd_i(stat_rd_i), .rxd_o(rxd_o),
  .rx_dv_o(rx_dv_o), .rx_er_o(rx_er_o), .crs_o(crs_o),
  .nib_stb_o(nib_stb_o), .prem_end_o(prem_end_o)
);

// File: tb/tb_pcs100_rx.sv
module tb_pcs100_rx;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_bit = 1'b1;
  logic       stat_rd = 1'b0;
  logic [3:0] rxd;
  logic       dv, er, crs, stb, prem;

  int n_chk = 0, n_fail = 0, cyc = 0, k_cyc = 0, log_n = 0;
  bit done = 1'b0;
  logic [3:0] lg_rxd [64];
  logic       lg_dv [64], lg_er [64], lg_crs [64];
  int         lg_cyc [64];

  // {nibble, code group}
  localparam logic [8:0] DATA_TAB [16] = '{
    {4'h0, 5'b11110}, {4'h1, 5'b01001}, {4'h2, 5'b10100}, {4'h3, 5'b10101},
    {4'h4, 5'b01010}, {4'h5, 5'b01011}, {4'h6, 5'b01110}, {4'h7, 5'b01111},
    {4'h8, 5'b10010}, {4'h9, 5'b10011}, {4'hA, 5'b10110}, {4'hB, 5'b10111},
    {4'hC, 5'b11010}, {4'hD, 5'b11011}, {4'hE, 5'b11100}, {4'hF, 5'b11101}};

  always #2.5 clk = ~clk;

  pcs100_rx dut (
    .clk_i(clk), .rst_ni(rst_n), .rx_bit_i(rx_bit), .stat_rd_i(stat_rd),
    .rxd_o(rxd), .rx_dv_o(dv), .rx_er_o(er), .crs_o(crs),
    .nib_stb_o(stb), .prem_end_o(prem)
  );

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rst_n && stb && log_n < 64) begin
      lg_rxd[log_n] = rxd; lg_dv[log_n] = dv; lg_er[log_n] = er;
      lg_crs[log_n] = crs; lg_cyc[log_n] = cyc;
      log_n = log_n + 1;
    end
  end

  always @(posedge clk) begin
    if (cyc > 20000 && !done) begin
      n_chk = n_chk + 1; n_fail = n_fail + 1;
      $display("FAIL watchdog act=%0d exp=<20000", cyc);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    n_chk = n_chk + 1;
    if (act != exp) begin
      n_fail = n_fail + 1;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk); rx_bit = b;
  endtask

  task automatic send_code(input logic [4:0] c);
    for (int i = 4; i >= 0; i--) send_bit(c[i]);
  endtask

  task automatic send_ones(input int n);
    for (int i = 0; i < n; i++) send_bit(1'b1);
  endtask

  task automatic send_ssd();
    send_code(5'b11000); send_code(5'b10001); k_cyc = cyc;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 rxd", rxd, 0); check("R1 dv", dv, 0); check("R1 er", er, 0);
    check("R1 crs", crs, 0); check("R1 stb", stb, 0); check("R1 prem", prem, 0);
    rst_n = 1'b1;
    send_ones(40);
    check("R2 no strobe", log_n, 0); check("R2 crs", crs, 0);

    // R3: adjacent zeros only
    send_bit(0); send_bit(0); send_ones(20);
    check("R3 noise strobe", log_n, 0); check("R3 noise crs", crs, 0);

    // R4 R5 R6: table frame, with carrier timing inside the delimiter
    log_n = 0;
    begin
      logic [9:0] ssd = 10'b11000_10001;
      for (int i = 0; i < 10; i++) begin
        send_bit(ssd[9-i]);
        if (i == 6) check("R3 crs before 2nd zero", crs, 0);
        if (i == 7) check("R3 crs after 2nd zero", crs, 1);
      end
      k_cyc = cyc;
    end
    for (int i = 0; i < 16; i++) send_code(DATA_TAB[i][4:0]);
    send_code(5'b01101); send_code(5'b00111); send_ones(20);
    check("R5 entry count", log_n, 19);
    for (int i = 0; i < 2; i++) begin
      check("R4 preamble rxd", lg_rxd[i], 5); check("R4 preamble dv", lg_dv[i], 1);
      check("R4 preamble crs", lg_crs[i], 1);
    end
    check("R4 first strobe time", lg_cyc[0], k_cyc + 1);
    for (int i = 0; i < 16; i++) begin
      check("R5 nibble", lg_rxd[i+2], int'(DATA_TAB[i][8:5]));
      check("R5 dv", lg_dv[i+2], 1); check("R5 er", lg_er[i+2], 0);
    end
    for (int i = 0; i < 19; i++) check("R11 cadence", lg_cyc[i], k_cyc + 1 + 5*i);
    check("R6 end dv", lg_dv[18], 0); check("R6 end er", lg_er[18], 0);
    check("R6 end crs", lg_crs[18], 0); check("R6 crs idle", crs, 0);
    check("R6 no prem", prem, 0);

    // R7: invalid group mid-frame
    log_n = 0;
    send_ssd(); send_code(5'b01011); send_code(5'b00000); send_code(5'b01110);
    send_code(5'b01101); send_code(5'b00111); send_ones(20);
    check("R7 count", log_n, 6);
    check("R7 before", lg_rxd[2], 5);
    check("R7 bad er", lg_er[3], 1); check("R7 bad dv", lg_dv[3], 1);
    check("R7 resume rxd", lg_rxd[4], 6); check("R7 resume er", lg_er[4], 0);
    check("R7 end dv", lg_dv[5], 0);

    // R8: premature idle
    log_n = 0;
    send_ssd(); send_code(5'b01111); send_code(5'b10010); send_code(5'b11111);
    send_ones(20);
    check("R8 count", log_n, 5);
    check("R8 pending rxd", lg_rxd[3], 8); check("R8 er", lg_er[3], 1);
    check("R8 dv", lg_dv[3], 1);
    check("R8 clear dv", lg_dv[4], 0); check("R8 clear er", lg_er[4], 0);
    check("R8 clear crs", lg_crs[4], 0); check("R8 clear gap", lg_cyc[4] - lg_cyc[3], 5);
    check("R8 sticky", prem, 1);
    send_ones(5);
    check("R10 held", prem, 1);
    @(negedge clk); stat_rd = 1'b1;
    @(negedge clk); stat_rd = 1'b0;
    check("R10 cleared", prem, 0);

    // R12: end delimiter with wrong second half
    log_n = 0;
    send_ssd(); send_code(5'b10101); send_code(5'b01101); send_code(5'b01011);
    send_ones(20);
    check("R12 count", log_n, 5);
    check("R12 last data", lg_rxd[2], 3);
    check("R12 er", lg_er[3], 1); check("R12 dv", lg_dv[3], 0);
    check("R12 clear er", lg_er[4], 0); check("R12 clear gap", lg_cyc[4] - lg_cyc[3], 5);
    check("R12 prem untouched", prem, 0);

    // R9: false carrier
    log_n = 0;
    send_bit(1); send_bit(1); send_bit(0); send_bit(1); send_bit(0);
    send_ones(5);
    send_ones(3);
    check("R9 crs during", crs, 1);
    send_ones(12);
    check("R9 count", log_n, 2);
    check("R9 rxd", lg_rxd[0], 14); check("R9 er", lg_er[0], 1);
    check("R9 dv", lg_dv[0], 0); check("R9 crs", lg_crs[0], 1);
    check("R9 clear er", lg_er[1], 0); check("R9 clear crs", lg_crs[1], 0);
    check("R9 ones run", lg_cyc[1] - lg_cyc[0], 10);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule